// File: doc/BRIEF.md
# Supervisory Reset and Backup Sequencer

This block is the synchronous controller of a microprocessor power supervisor. Analog comparators outside the block report four supply conditions as digital flags: supply under the reset threshold, supply under the battery voltage, supply above the battery voltage with margin, and supply under the low-line threshold. The block also takes an active-low manual reset, a watchdog-fault request and a reseal request. From these it drives an active-high and an active-low system reset, a battery-on flag, a backup-select signal for the rail switch, and an active-low low-line warning.

Every input passes through a two-flop synchronizer. The reset output is stretched by a timeout counted in ticks of a prescaled clock, so the release delay is `TIMEOUT_TICKS * PRESCALE` clock cycles after the last reset cause clears. A seal latch keeps the battery from ever being switched onto the output rail until main supply has been present once. A reseal request, honoured only while the supply is absent, closes the latch again.

Backup mode is entered on one set of flags and left on another, so the rail switch has hysteresis. The low-line output warns ahead of reset as the supply falls. On power-up it is held until reset has released.

Top module: `supv_reset_seq`

## Requirements
- R1: Both reset outputs are asserted (`rst_o`=1, `rst_no`=0) while the synchronized supply-under-reset flag is high, while the filtered manual reset is active, or while backup mode is active. They are also asserted out of block reset, with `bat_on_o`=0 and `low_line_no`=0.
- R2: After every reset cause has cleared, reset stays asserted for `TIMEOUT_TICKS` ticks of `PRESCALE` cycles each, then releases. A cause that returns during the timeout restarts the full count.
- R3: A manual-reset low pulse shorter than `MR_FILT` clock cycles has no effect on the reset outputs. A low level held longer than that asserts reset.
- R4: A rising edge on `wdt_fault_i` produces exactly one full reset timeout. Holding the request high does not retrigger it.
- R5: Backup mode is entered only when the seal is open and the supply is both under the reset threshold and under the battery voltage.
- R6: Once in backup, the block leaves backup only when `above_batt_i` is high. The supply-under-battery flag dropping alone keeps backup active.
- R7: `bat_on_o` and `bkup_sel_o` are both high exactly while backup mode is active, and reset stays asserted throughout backup.
- R8: The seal opens the first time the supply rises above the reset threshold. While the seal is closed, backup is never selected, even with only the battery present.
- R9: `reseal_i` closes the seal only while the supply is under the reset threshold. Closing the seal leaves backup at once. A reseal request while the supply is present is ignored.
- R10: `low_line_no` is low while the low-line flag is high or reset is asserted. It goes high no earlier than one cycle after reset has released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| below_rst_i | input | 1 | Supply under the reset threshold |
| below_batt_i | input | 1 | Supply under the battery voltage |
| above_batt_i | input | 1 | Supply above the battery voltage with margin (backup exit) |
| low_line_i | input | 1 | Supply under the low-line threshold |
| man_rst_ni | input | 1 | Manual reset, active low |
| wdt_fault_i | input | 1 | Watchdog-fault request; rising edge triggers a reset pulse |
| reseal_i | input | 1 | Request to close the battery seal |
| rst_no | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |
| bat_on_o | output | 1 | Battery-on flag |
| bkup_sel_o | output | 1 | Rail switch select, 1 selects the battery |
| low_line_no | output | 1 | Low-line warning, active low |

## Verification
If the seal latch or the backup state holds a wrong value, `bat_on_o` and `bkup_sel_o` show it within three cycles of the flag pattern that should decide it. That pattern is battery-only start, a brownout while the seal is closed, or a reseal with the supply present or absent. A wrong timeout count or prescaler phase moves the release edge of `rst_no`, which the bench checks shortly before and shortly after the expected release. The low-line path is checked at the exact cycle of reset release, where `low_line_no` must still be low, and one cycle later.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int NSYNC     = 7;
  localparam int IDX_BRST  = 0;
  localparam int IDX_BBAT  = 1;
  localparam int IDX_ABAT  = 2;
  localparam int IDX_LL    = 3;
  localparam int IDX_MR    = 4;
  localparam int IDX_WDT   = 5;
  localparam int IDX_RSEAL = 6;

  typedef logic [NSYNC-1:0] sync_vec_t;

  // Safe power-on view: supply absent, low line, manual reset released
  localparam sync_vec_t SYNC_RST = 7'b001_1001;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int MR_FILT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_n_i,
  output logic act_o
);
  localparam int FW = $clog2(MR_FILT + 1);

  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (mr_n_i)                    cnt_q <= '0;
    else if (cnt_q != FW'(MR_FILT))     cnt_q <= cnt_q + 1'b1;
  end

  assign act_o = (cnt_q == FW'(MR_FILT));

  // R3: activation only follows a low sample
  p_glitch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o) |-> $past(!mr_n_i));
endmodule

// File: rtl/supv_timeout.sv
module supv_timeout #(
  parameter int PRESCALE      = 50000,
  parameter int TIMEOUT_TICKS = 215
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic fire_i,
  output logic active_o
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, tick, load;

  always_comb begin
    load   = hold_i | fire_i;
    tick   = (pcnt_q == PW'(PRESCALE - 1));
    pcnt_d = (load || tick) ? '0 : pcnt_q + 1'b1;
    if (load)                    cnt_d = CW'(TIMEOUT_TICKS);
    else if (tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                         cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cnt_q  <= CW'(TIMEOUT_TICKS);
      act_q  <= 1'b1;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
      act_q  <= (cnt_d != 0);
    end
  end

  assign active_o = act_q;

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> active_o);
  p_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> active_o);
  p_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(!hold_i && !fire_i));
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int PRESCALE      = 50000,
  parameter int TIMEOUT_TICKS = 215,
  parameter int MR_FILT       = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_rst_i,
  input  logic below_batt_i,
  input  logic above_batt_i,
  input  logic low_line_i,
  input  logic man_rst_ni,
  input  logic wdt_fault_i,
  input  logic reseal_i,
  output logic rst_no,
  output logic rst_o,
  output logic bat_on_o,
  output logic bkup_sel_o,
  output logic low_line_no
);
  sync_vec_t raw, syn;
  logic      mr_act, wdt_q, wd_pulse, req, rst_q;
  logic      seal_q, bat_q, bat_d, ll_n_q;
  logic      s_brst, s_bbat, s_abat, s_ll, s_rseal;

  assign raw = {reseal_i, wdt_fault_i, man_rst_ni, low_line_i,
                above_batt_i, below_batt_i, below_rst_i};

  supv_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn));

  assign s_brst  = syn[IDX_BRST];
  assign s_bbat  = syn[IDX_BBAT];
  assign s_abat  = syn[IDX_ABAT];
  assign s_ll    = syn[IDX_LL];
  assign s_rseal = syn[IDX_RSEAL];

  supv_mr_filter #(.MR_FILT(MR_FILT)) u_mr (
    .clk_i(clk_i), .rst_ni(rst_ni), .mr_n_i(syn[IDX_MR]), .act_o(mr_act));

  assign wd_pulse = syn[IDX_WDT] & ~wdt_q;

  // Seal opens on first supply presence; reseal honoured only with supply absent
  always_comb begin
    if (!seal_q)    bat_d = 1'b0;
    else if (bat_q) bat_d = ~s_abat;
    else            bat_d = s_brst & s_bbat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q  <= 1'b0;
      seal_q <= 1'b0;
      bat_q  <= 1'b0;
    end else begin
      wdt_q <= syn[IDX_WDT];
      if (s_rseal && s_brst) seal_q <= 1'b0;
      else if (!s_brst)      seal_q <= 1'b1;
      bat_q <= bat_d;
    end
  end

  assign req = s_brst | mr_act | bat_q;

  supv_timeout #(.PRESCALE(PRESCALE), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(req), .fire_i(wd_pulse),
    .active_o(rst_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ll_n_q <= 1'b0;
    else         ll_n_q <= ~(s_ll | rst_q);
  end

  assign rst_o       = rst_q;
  assign rst_no      = ~rst_q;
  assign bat_on_o    = bat_q;
  assign bkup_sel_o  = bat_q;
  assign low_line_no = ll_n_q;

  p_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bat_q) |-> $past(seal_q && s_brst && s_bbat));
  p_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bat_q) |-> $past(s_abat || !seal_q));
  p_bkup_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_q |=> rst_q);
  p_sealed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seal_q |=> !bat_q);
  p_reseal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(seal_q) |-> $past(s_brst && s_rseal));
  p_ll_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ll_n_q) |-> $past(!rst_q));
endmodule

// File: tb/supv_reset_seq_tb.sv
module supv_reset_seq_tb;
  localparam int P  = 4;
  localparam int T  = 10;
  localparam int TP = P * T;
  localparam int MF = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic below_rst, below_batt, above_batt, low_line, man_rst_n, wdt_fault, reseal;
  logic rst_no, rst_o, bat_on, bkup_sel, low_line_no;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic  rst;
    logic  bat;
    logic  ll_n;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  supv_reset_seq #(.PRESCALE(P), .TIMEOUT_TICKS(T), .MR_FILT(MF)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .below_rst_i(below_rst), .below_batt_i(below_batt),
    .above_batt_i(above_batt), .low_line_i(low_line), .man_rst_ni(man_rst_n),
    .wdt_fault_i(wdt_fault), .reseal_i(reseal), .rst_no(rst_no), .rst_o(rst_o),
    .bat_on_o(bat_on), .bkup_sel_o(bkup_sel), .low_line_no(low_line_no));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input logic r, input logic b, input logic l, input string tag);
    exp_t e;
    e.rst = r; e.bat = b; e.ll_n = l; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [4:0] act, exp;
        e   = exp_q.pop_front();
        act = {rst_o, rst_no, bat_on, bkup_sel, low_line_no};
        exp = {e.rst, ~e.rst, e.bat, e.bat, e.ll_n};
        checks++;
        if (act !== exp) begin
          failures++;
          $display("FAIL %s: {rst,rst_n,bat_on,sel,ll_n} actual=%b expected=%b", e.tag, act, exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // battery only: supply absent, under battery
    below_rst = 1; below_batt = 1; above_batt = 0; low_line = 1;
    man_rst_n = 1; wdt_fault = 0; reseal = 0;
    wait_cyc(3);
    expect_now(1, 0, 0, "R1 block reset state");
    rst_ni = 1;
    wait_cyc(20);
    expect_now(1, 0, 0, "R8 battery only, no backup");

    // power up
    below_rst = 0; below_batt = 0; above_batt = 1; low_line = 0;
    wait_cyc(TP - 4);
    expect_now(1, 0, 0, "R2 held before timeout");
    wait_cyc(6);
    expect_now(0, 0, 0, "R10 reset released, low line still held");
    wait_cyc(1);
    expect_now(0, 0, 1, "R10 low line follows reset release");

    // manual reset glitch
    man_rst_n = 0;
    wait_cyc(MF - 1);
    man_rst_n = 1;
    wait_cyc(10);
    expect_now(0, 0, 1, "R3 short manual pulse ignored");

    // manual reset held
    man_rst_n = 0;
    wait_cyc(10);
    expect_now(1, 0, 0, "R1 manual reset asserts");
    man_rst_n = 1;
    wait_cyc(TP - 4);
    expect_now(1, 0, 0, "R2 manual timeout still running");
    wait_cyc(12);
    expect_now(0, 0, 1, "R2 manual timeout ended");

    // restart of the timeout by a returning cause
    man_rst_n = 0;
    wait_cyc(10);
    man_rst_n = 1;
    wait_cyc(TP / 2);
    man_rst_n = 0;
    wait_cyc(10);
    man_rst_n = 1;
    wait_cyc(TP - 4);
    expect_now(1, 0, 0, "R2 timeout restarted");
    wait_cyc(12);
    expect_now(0, 0, 1, "R2 restarted timeout ended");

    // watchdog fault held high
    wdt_fault = 1;
    wait_cyc(6);
    expect_now(1, 0, 0, "R4 watchdog pulse asserts");
    wait_cyc(TP - 10);
    expect_now(1, 0, 0, "R4 watchdog pulse full length");
    wait_cyc(14);
    expect_now(0, 0, 1, "R4 held request no retrigger");
    wait_cyc(TP);
    expect_now(0, 0, 1, "R4 still single pulse");
    wdt_fault = 0;
    wait_cyc(4);

    // brownout into backup
    low_line = 1;
    wait_cyc(6);
    expect_now(0, 0, 0, "R10 low line ahead of reset");
    below_rst = 1; above_batt = 0;
    wait_cyc(6);
    expect_now(1, 0, 0, "R5 above battery, no backup");
    below_batt = 1;
    wait_cyc(6);
    expect_now(1, 1, 0, "R5 backup entered");

    // hysteresis band
    below_batt = 0;
    wait_cyc(6);
    expect_now(1, 1, 0, "R6 backup kept in hysteresis band");
    below_rst = 0;
    wait_cyc(TP + 10);
    expect_now(1, 1, 0, "R7 reset held during backup");

    // exit backup
    above_batt = 1; low_line = 0;
    wait_cyc(6);
    expect_now(1, 0, 0, "R6 backup left on margin flag");
    wait_cyc(TP + 4);
    expect_now(0, 0, 1, "R2 release after backup");

    // reseal with supply present is ignored
    reseal = 1;
    wait_cyc(6);
    reseal = 0;
    low_line = 1; below_rst = 1; below_batt = 1; above_batt = 0;
    wait_cyc(8);
    expect_now(1, 1, 0, "R9 reseal ignored while supply present");

    // reseal with supply absent
    reseal = 1;
    wait_cyc(6);
    expect_now(1, 0, 0, "R9 reseal leaves backup");
    reseal = 0;
    below_batt = 0;
    wait_cyc(4);
    below_batt = 1;
    wait_cyc(8);
    expect_now(1, 0, 0, "R8 sealed, no backup");

    // power returns, seal opens again
    below_rst = 0; below_batt = 0; above_batt = 1; low_line = 0;
    wait_cyc(TP + 10);
    expect_now(0, 0, 1, "R2 release after power return");
    low_line = 1; below_rst = 1; below_batt = 1; above_batt = 0;
    wait_cyc(8);
    expect_now(1, 1, 0, "R8 seal reopened, backup allowed");

    wait_cyc(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule